// File: doc/BRIEF.md
# Indirect Register Window with Auto-Increment

This block lets a host reach a bank of 16-bit internal registers through just two direct locations. One location holds an index. The other is a data window onto the register that the index selects. The host loads the index and then reads or writes the window. After each complete window access the index moves forward by one, so the host can stream through consecutive registers without reloading it.

The host bus works in one of two widths, chosen by a mode pin. On the 16-bit bus a single window access moves a whole register. On the 8-bit bus each register moves as two byte accesses. The low byte goes first: a written low byte waits in a staging register, and a low-byte read captures the whole register. The high byte access then completes the transfer, and only that access advances the index. The bank is a plain array addressed by the low bits of the index.

Top module: `ind_reg_window`

## Requirements
- R1: After reset, the index is 0x0000, every bank entry is 0x0000 and the staging and snapshot registers are zero.
- R2: A write to word select 0 (byte offset 0x00) updates index bits 7:0 when be[0] is set and bits 15:8 when be[1] is set. be[3:2] have no effect. A read there returns the index in rdata[15:0] with rdata[31:16] zero.
- R3: With bus8=0, a write to word select 1 (byte offset 0x04) with any of be[1:0] set updates the byte lanes of the indexed entry that be[1:0] enable, and the index then increments by one.
- R4: With bus8=0, a read of word select 1 returns the indexed entry in rdata[15:0] with rdata[31:16] zero. When any of be[1:0] is set, the index then increments by one.
- R5: With bus8=1, a window write with be[1:0]=01 places wdata[7:0] in the staging register. It leaves the bank and the index unchanged.
- R6: With bus8=1, a window write with be[1] set stores {wdata[15:8], low} in the indexed entry and increments the index. Here low is wdata[7:0] when be[0] is also set, and the staged byte otherwise.
- R7: With bus8=1, a window read with be[1:0]=01 returns the entry's low byte in rdata[7:0], captures the whole entry as a snapshot, and leaves the index unchanged. A later read with be[1:0]=10 returns the snapshot's high byte in rdata[15:8] and increments the index. When both bytes are enabled, the read returns the live entry.
- R8: The index wraps from 0xFFFF to 0x0000 on increment.
- R9: The bank entry selected is the index modulo DEPTH (DEPTH=64 by default).
- R10: With cs low, or with word select 2 or 3, nothing changes and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus8 | input | 1 | 1 selects the 8-bit host bus, 0 the 16-bit host bus |
| cs | input | 1 | Access strobe, one access per cycle it is high |
| we | input | 1 | 1 for write, 0 for read |
| wsel | input | 2 | Word select: byte offset divided by four |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data, bytes on their own lanes |
| rdata | output | 32 | Read data, combinational during the access |

## Verification
On every cycle the assertions check how the index moves: it stays put when there is no strobe, when the word select is unused, and on low-byte-only window accesses. It advances by exactly one on completing window accesses, and rdata's reserved half stays zero. Other behaviour shows only in the bench's scenarios. These include the data path through the bank and the pairing of a staged low byte with a later high byte. They also include the snapshot, which keeps the high byte stable even after the entry is rewritten, together with index wraparound and aliasing modulo the bank depth.

// File: rtl/ind_reg_window.sv
module ind_reg_window #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus8,
  input  logic        cs,
  input  logic        we,
  input  logic [1:0]  wsel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [15:0] idx;
  logic [7:0]  stage;
  logic [15:0] snap;
  logic [15:0] bank [DEPTH];

  wire          sel_idx = cs && (wsel == 2'd0);
  wire          sel_win = cs && (wsel == 2'd1);
  wire [AW-1:0] slot    = idx[AW-1:0];
  wire [15:0]   cur     = bank[slot];
  wire          step    = sel_win && (bus8 ? be[1] : (be[1] | be[0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      stage <= '0;
      snap  <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      if (sel_idx && we) begin
        if (be[0]) idx[7:0]  <= wdata[7:0];
        if (be[1]) idx[15:8] <= wdata[15:8];
      end else if (step) begin
        idx <= idx + 16'd1;
      end
      if (sel_win && we) begin
        if (!bus8) begin
          if (be[0]) bank[slot][7:0]  <= wdata[7:0];
          if (be[1]) bank[slot][15:8] <= wdata[15:8];
        end else begin
          if (be[1]) bank[slot] <= {wdata[15:8], be[0] ? wdata[7:0] : stage};
          else if (be[0]) stage <= wdata[7:0];
        end
      end
      if (sel_win && !we && bus8 && be[0] && !be[1]) snap <= cur;
    end
  end

  logic [15:0] win_rd;
  always_comb begin
    if (!bus8 || be[0]) win_rd = cur;
    else                win_rd = {snap[15:8], 8'h00};
  end

  assign rdata = (cs && !we && wsel == 2'd0) ? {16'h0000, idx} :
                 (cs && !we && wsel == 2'd1) ? {16'h0000, win_rd} : 32'h0;
endmodule

module ind_reg_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus8,
  input logic        cs,
  input logic        we,
  input logic [1:0]  wsel,
  input logic [3:0]  be,
  input logic [31:0] rdata,
  input logic [15:0] idx
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == 16'h0000);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs || wsel[1]) |=> $stable(idx));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> rdata == 32'h0);

  a_r5_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wsel == 2'd1 && bus8 && be[1:0] == 2'b01) |=> $stable(idx));

  a_r3_step16: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wsel == 2'd1 && !bus8 && be[1:0] != 2'b00) |=> idx == $past(idx) + 16'd1);

  a_r6_step8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wsel == 2'd1 && bus8 && be[1]) |=> idx == $past(idx) + 16'd1);
endmodule

bind ind_reg_window ind_reg_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus8(bus8), .cs(cs), .we(we),
  .wsel(wsel), .be(be), .rdata(rdata), .idx(idx)
);

// File: tb/ind_reg_window_test.sv
module ind_reg_window_test;
  localparam int DEPTH = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus8 = 0, cs = 0, we = 0;
  logic [1:0]  wsel = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;

  int tests = 0, fails = 0;
  logic [15:0] m_bank [DEPTH];
  logic [15:0] m_idx;
  logic [7:0]  m_stage;
  logic [15:0] m_snap;

  always #5 clk = ~clk;

  ind_reg_window #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus8(bus8), .cs(cs), .we(we),
    .wsel(wsel), .be(be), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic m8, logic w, logic [1:0] s, logic [3:0] b);
    logic [15:0] e;
    if (w) return 32'h0;
    if (s == 2'd0) return {16'h0, m_idx};
    if (s != 2'd1) return 32'h0;
    e = m_bank[m_idx % DEPTH];
    if (!m8 || b[0]) return {16'h0, e};
    return {16'h0, m_snap[15:8], 8'h00};
  endfunction

  task automatic model_update(logic m8, logic w, logic [1:0] s, logic [3:0] b, logic [31:0] d);
    int a;
    a = m_idx % DEPTH;
    if (s == 2'd0 && w) begin
      if (b[0]) m_idx[7:0]  = d[7:0];
      if (b[1]) m_idx[15:8] = d[15:8];
    end else if (s == 2'd1) begin
      if (w) begin
        if (!m8) begin
          if (b[0]) m_bank[a][7:0]  = d[7:0];
          if (b[1]) m_bank[a][15:8] = d[15:8];
        end else if (b[1]) m_bank[a] = {d[15:8], b[0] ? d[7:0] : m_stage};
        else if (b[0]) m_stage = d[7:0];
      end else if (m8 && b[1:0] == 2'b01) m_snap = m_bank[a];
      if (m8 ? b[1] : (b[1] | b[0])) m_idx = m_idx + 16'd1;
    end
  endtask

  task automatic op(string req, logic m8, logic c, logic w, logic [1:0] s, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    bus8 = m8; cs = c; we = w; wsel = s; be = b; wdata = d;
    #1;
    check(req, rdata, c ? exp_rd(m8, w, s, b) : 32'h0);
    @(posedge clk);
    if (c) model_update(m8, w, s, b, d);
    #1 cs = 0;
  endtask

  task automatic peek_idx(string req);
    op(req, 0, 1, 0, 2'd0, 4'b0011, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_bank[i] = 0;
    m_idx = 0; m_stage = 0; m_snap = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    peek_idx("R1");
    op("R1", 0, 1, 0, 2'd1, 4'b0011, 0);

    // R2 index write with upper enables ignored
    op("R2", 0, 1, 1, 2'd0, 4'b1111, 32'hABCD_0005);
    peek_idx("R2");
    op("R2", 0, 1, 1, 2'd0, 4'b0001, 32'h0000_FF10);
    peek_idx("R2");

    // R3 / R4 16-bit streaming
    op("R2", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_0008);
    for (int i = 0; i < 4; i++) op("R3", 0, 1, 1, 2'd1, 4'b0011, 32'h1100 + i);
    op("R3", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_0008);
    op("R3", 0, 1, 1, 2'd1, 4'b0010, 32'h0000_7700);
    op("R3", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_0008);
    for (int i = 0; i < 4; i++) op("R4", 0, 1, 0, 2'd1, 4'b0011, 0);
    peek_idx("R4");

    // R5 / R6 8-bit write pair
    op("R2", 1, 1, 1, 2'd0, 4'b0011, 32'h0000_0020);
    op("R5", 1, 1, 1, 2'd1, 4'b0001, 32'h0000_005A);
    peek_idx("R5");
    op("R5", 0, 1, 0, 2'd1, 4'b0011, 0);
    op("R2", 1, 1, 1, 2'd0, 4'b0011, 32'h0000_0020);
    op("R6", 1, 1, 1, 2'd1, 4'b0010, 32'h0000_C300);
    peek_idx("R6");
    op("R2", 1, 1, 1, 2'd0, 4'b0011, 32'h0000_0020);
    op("R6", 0, 1, 0, 2'd1, 4'b0011, 0);

    // R7 8-bit read pair with snapshot kept across rewrite
    op("R2", 1, 1, 1, 2'd0, 4'b0011, 32'h0000_0020);
    op("R7", 1, 1, 0, 2'd1, 4'b0001, 0);
    peek_idx("R7");
    op("R7", 0, 1, 1, 2'd1, 4'b0011, 32'h0000_0EEE);
    op("R2", 1, 1, 1, 2'd0, 4'b0011, 32'h0000_0020);
    op("R7", 1, 1, 0, 2'd1, 4'b0010, 0);
    peek_idx("R7");

    // R8 wrap, R9 aliasing
    op("R2", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_FFFF);
    op("R8", 0, 1, 1, 2'd1, 4'b0011, 32'h0000_BEEF);
    peek_idx("R8");
    op("R9", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_003F);
    op("R9", 0, 1, 0, 2'd1, 4'b0011, 0);
    op("R9", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_0000 + DEPTH + 3);
    op("R9", 0, 1, 1, 2'd1, 4'b0011, 32'h0000_1234);
    op("R9", 0, 1, 1, 2'd0, 4'b0011, 32'h0000_0003);
    op("R9", 0, 1, 0, 2'd1, 4'b0011, 0);

    // R10 idle and unused selects
    op("R10", 0, 0, 1, 2'd1, 4'b0011, 32'h0000_9999);
    op("R10", 0, 1, 1, 2'd2, 4'b1111, 32'hFFFF_FFFF);
    op("R10", 1, 1, 0, 2'd3, 4'b1111, 0);
    peek_idx("R10");
    op("R10", 0, 1, 0, 2'd1, 4'b0011, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] s;
      logic [3:0] b;
      logic [31:0] d;
      s = $urandom_range(0, 3);
      b = 4'($urandom);
      d = $urandom;
      if (s == 2'd0 && $urandom_range(0, 1) == 0) d[15:6] = 0;
      op("R3/R4/R6/R7 random", 1'($urandom), 1'($urandom_range(0, 7) != 0),
         1'($urandom), s, b, d);
    end
    peek_idx("R2 final");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule